// File: doc/BRIEF.md
# Full-speed USB receive framer

This block sits behind the line receiver and clock recovery of a full-speed USB device. It takes one decoded line state per bit time (SE0, J, K or SE1), qualified by a bit strobe. It looks for the start-of-packet pattern and removes stuffed bits. It NRZI-decodes the bit stream and hands whole bytes, least significant bit first, to the packet engines. The engines also receive a packet-start strobe, a packet-end strobe and a packet-valid flag. Together these mark where each packet begins and ends, and whether it can be trusted.

The framer is built to keep going when the line is noisy. Every packet that raised a start strobe is closed with an end strobe, so a downstream state machine never waits forever for the end of a damaged packet. After a framing error the framer goes deaf. A SYNC-like bit run inside the rest of that packet cannot start a new packet. The framer only listens again once the line has gone to SE0 and come back to J.

Line state encoding on `line_st`: 2'b00 = SE0, 2'b01 = J, 2'b10 = K, 2'b11 = SE1. All behaviour advances only on clock cycles where `bit_stb` is high. Outputs are registered at that edge.

Top module: `fs_rx_framer`

## Requirements
- R1: After reset all outputs are low and the framer acts on nothing until it samples J. A K J K J K K run that begins before the first J therefore raises no packet-start.
- R2: From idle, when the six most recent line states, oldest first, are K J K J K K, `pkt_start` pulses on the cycle after that sample.
- R3: At packet-start, `pkt_valid` is set only if the last eight states were K J K J K J K K; otherwise it is cleared. `pkt_valid` rises at no other time, is cleared by any error, and otherwise holds until the next packet-start.
- R4: `pkt_end` pulses once for every packet-start. In a clean packet it pulses on the J sample that follows at least two SE0 samples. After an error it pulses on the first J that follows at least two consecutive SE0 samples. During the pulse, `pkt_valid` shows the packet's final validity.
- R5: After six consecutive decoded ones, the next J/K sample is a stuffed bit. A level change there is dropped and counted as no data bit. An unchanged level is a stuffing violation: `pkt_valid` clears and the framer goes deaf.
- R6: While deaf after a started packet, a K J K J K K run raises no packet-start and no byte strobe. A single SE0 followed by J does not end the packet.
- R7: In idle, two consecutive K samples that do not complete the start pattern, or an SE0 or SE1 sample, count as a failed SYNC. Such a failure raises no packet-start and no packet-end. The framer then ignores the line until it samples at least one SE0 followed by J.
- R8: A data bit is 1 when the level equals the previous J/K level and 0 when it changes. The reference for the first bit is the final K of the start pattern. Bits are packed LSB first. `byte_stb` pulses with `byte_data` once per eight unstuffed bits, whether or not the packet is valid.
- R9: Inside a packet, an SE1 sample is an error. So is a J or K that follows exactly one SE0, and a K that follows two SE0 samples. An error clears `pkt_valid` and leaves the end strobe owed.
- R10: `pkt_start`, `pkt_end` and `byte_stb` are single-cycle pulses. On cycles with `bit_stb` low, no strobe rises on the next cycle and `pkt_valid` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle qualifier marking a new line-state sample |
| line_st | input | 2 | Decoded line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| pkt_start | output | 1 | Pulse: start pattern seen |
| pkt_end | output | 1 | Pulse: end of a started packet |
| pkt_valid | output | 1 | Current packet still trusted |
| byte_stb | output | 1 | Pulse: byte_data carries a new byte |
| byte_data | output | 8 | Received byte, LSB first on the wire |

## Verification
The assertions check the pulse shape and pacing of the strobes on every cycle. They also check that packet-start and packet-end alternate, that bytes and ends appear only inside a start/end bracket, and that validity can only rise together with a packet-start. Only the bench scenarios can show the rest. These cover decoded byte values across stuffed runs, the validity verdict for full versus truncated SYNC, deafness to SYNC-like runs after a stuffing violation or a bad EOP, and the failed-SYNC lockout that lasts until SE0 and J.

// File: rtl/fs_rx_framer.sv
module fs_rx_framer #(
  parameter int STUFF_RUN = 6,
  parameter int EOP_SE0   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic [1:0] line_st,
  output logic       pkt_start,
  output logic       pkt_end,
  output logic       pkt_valid,
  output logic       byte_stb,
  output logic [7:0] byte_data
);

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;
  localparam logic [1:0] LS_SE1 = 2'b11;
  localparam logic [15:0] SYNC8  = {LS_K, LS_J, LS_K, LS_J, LS_K, LS_J, LS_K, LS_K};
  localparam logic [15:0] IDLE_H = {8{LS_J}};
  localparam int RW = $clog2(STUFF_RUN + 1);
  localparam int SW = $clog2(EOP_SE0 + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(STUFF_RUN);
  localparam logic [SW-1:0] SE0_MAX = SW'(EOP_SE0);
  localparam logic [SW-1:0] SE0_ONE = SW'(1);

  typedef enum logic [1:0] {S_WAITJ, S_IDLE, S_RECV, S_DEAF} st_t;

  st_t           state;
  logic [15:0]   hist;
  logic [1:0]    prev;
  logic [RW-1:0] ones;
  logic [SW-1:0] se0n;
  logic [2:0]    bitn;
  logic [6:0]    sr;
  logic          owe_end;

  wire [15:0]   hist_n   = {hist[13:0], line_st};
  wire          sync_hit = hist_n[11:0] == SYNC8[11:0];
  wire          sync_ok  = hist_n == SYNC8;
  wire          double_k = hist_n[3:0] == {LS_K, LS_K};
  wire          is_lvl   = (line_st == LS_J) || (line_st == LS_K);
  wire          dbit     = line_st == prev;
  wire          stuffing = ones == RUN_MAX;
  wire [SW-1:0] se0_inc  = (se0n == SE0_MAX) ? se0n : se0n + SE0_ONE;
  wire [SW-1:0] need     = owe_end ? SE0_MAX : SE0_ONE;
  wire          eop_ok   = (line_st == LS_J) && (se0n == SE0_MAX);
  wire          rx_err   = (line_st == LS_SE1) ||
                           ((se0n != '0) && !eop_ok) ||
                           ((se0n == '0) && stuffing && dbit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_WAITJ;
      hist      <= IDLE_H;
      prev      <= LS_J;
      ones      <= '0;
      se0n      <= '0;
      bitn      <= '0;
      sr        <= '0;
      owe_end   <= 1'b0;
      pkt_start <= 1'b0;
      pkt_end   <= 1'b0;
      pkt_valid <= 1'b0;
      byte_stb  <= 1'b0;
      byte_data <= '0;
    end else begin
      pkt_start <= 1'b0;
      pkt_end   <= 1'b0;
      byte_stb  <= 1'b0;
      if (bit_stb) begin
        case (state)
          S_WAITJ: begin
            if (line_st == LS_J) begin
              state <= S_IDLE;
              hist  <= IDLE_H;
            end
          end
          S_IDLE: begin
            if (!is_lvl) begin
              state   <= S_DEAF;
              owe_end <= 1'b0;
              se0n    <= (line_st == LS_SE0) ? SE0_ONE : '0;
            end else if (sync_hit) begin
              state     <= S_RECV;
              pkt_start <= 1'b1;
              pkt_valid <= sync_ok;
              prev      <= LS_K;
              ones      <= '0;
              bitn      <= '0;
              se0n      <= '0;
              hist      <= hist_n;
            end else if (double_k) begin
              state   <= S_DEAF;
              owe_end <= 1'b0;
              se0n    <= '0;
            end else begin
              hist <= hist_n;
            end
          end
          S_RECV: begin
            if (line_st == LS_SE0) begin
              se0n <= se0_inc;
            end else if (rx_err) begin
              state     <= S_DEAF;
              owe_end   <= 1'b1;
              se0n      <= '0;
              pkt_valid <= 1'b0;
            end else if (se0n != '0) begin
              state   <= S_IDLE;
              pkt_end <= 1'b1;
              hist    <= IDLE_H;
              se0n    <= '0;
            end else begin
              prev <= line_st;
              if (stuffing) begin
                ones <= '0;
              end else begin
                ones <= dbit ? ones + 1'b1 : '0;
                sr   <= {dbit, sr[6:1]};
                bitn <= bitn + 3'd1;
                if (bitn == 3'd7) begin
                  byte_stb  <= 1'b1;
                  byte_data <= {dbit, sr};
                end
              end
            end
          end
          default: begin
            if (line_st == LS_SE0) begin
              se0n <= se0_inc;
            end else if ((line_st == LS_J) && (se0n >= need)) begin
              state   <= S_IDLE;
              pkt_end <= owe_end;
              owe_end <= 1'b0;
              hist    <= IDLE_H;
              se0n    <= '0;
            end else begin
              se0n <= '0;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/fs_rx_framer_chk.sv
module fs_rx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic pkt_start,
  input logic pkt_end,
  input logic pkt_valid,
  input logic byte_stb
);

  logic in_pkt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_pkt <= 1'b0;
    else if (pkt_start) in_pkt <= 1'b1;
    else if (pkt_end) in_pkt <= 1'b0;
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) pkt_start |=> !pkt_start); // R10
  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n) pkt_end |=> !pkt_end); // R10
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !bit_stb |=> !(pkt_start || pkt_end || byte_stb)); // R10
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bit_stb |=> $stable(pkt_valid)); // R10
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(pkt_valid) |-> pkt_start); // R3
  AST_END_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n) pkt_end |-> in_pkt); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) pkt_start |-> !in_pkt); // R6
  AST_BYTE_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n) byte_stb |-> in_pkt); // R8

endmodule

bind fs_rx_framer fs_rx_framer_chk chk_i (.*);

// File: tb/fs_rx_framer_test.sv
module fs_rx_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SE0 = 0, J = 1, K = 2, SE1 = 3;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0;
  logic [1:0] line_st = 2'b01;
  logic pkt_start, pkt_end, pkt_valid, byte_stb;
  logic [7:0] byte_data;

  fs_rx_framer uut (.clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .line_st(line_st),
    .pkt_start(pkt_start), .pkt_end(pkt_end), .pkt_valid(pkt_valid),
    .byte_stb(byte_stb), .byte_data(byte_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  int pat[8] = '{K, J, K, J, K, J, K, K};
  int hq[$];
  int m_st, m_prev, m_ones, m_se0, m_owe, m_bits, m_acc;
  int e_start, e_end, e_bstb, e_byte, e_valid;

  task automatic m_idle();
    hq.delete();
    repeat (8) hq.push_back(J);
  endtask

  task automatic m_err();
    m_st = 3; m_owe = 1; m_se0 = 0; e_valid = 0;
  endtask

  task automatic m_step(int ls);
    int hit6, full, b;
    case (m_st)
      0: if (ls == J) begin m_st = 1; m_idle(); end
      1: begin
        if (ls == SE0 || ls == SE1) begin
          m_st = 3; m_owe = 0; m_se0 = (ls == SE0) ? 1 : 0;
        end else begin
          hq.push_back(ls);
          void'(hq.pop_front());
          hit6 = 1; full = 1;
          for (int i = 0; i < 8; i++)
            if (hq[i] != pat[i]) begin full = 0; if (i >= 2) hit6 = 0; end
          if (hit6 == 1) begin
            e_start = 1; e_valid = full; m_st = 2; m_prev = K;
            m_ones = 0; m_bits = 0; m_acc = 0; m_se0 = 0;
          end else if (hq[6] == K && hq[7] == K) begin
            m_st = 3; m_owe = 0; m_se0 = 0;
          end
        end
      end
      2: begin
        if (ls == SE0) m_se0 = (m_se0 >= 2) ? 2 : m_se0 + 1;
        else if (ls == SE1) m_err();
        else if (m_se0 > 0) begin
          if (m_se0 >= 2 && ls == J) begin e_end = 1; m_st = 1; m_idle(); m_se0 = 0; end
          else m_err();
        end else begin
          b = (ls == m_prev) ? 1 : 0;
          m_prev = ls;
          if (m_ones == 6) begin
            if (b == 1) m_err(); else m_ones = 0;
          end else begin
            m_ones = (b == 1) ? m_ones + 1 : 0;
            m_acc = m_acc | (b << m_bits);
            m_bits++;
            if (m_bits == 8) begin e_bstb = 1; e_byte = m_acc; m_acc = 0; m_bits = 0; end
          end
        end
      end
      default: begin
        if (ls == SE0) m_se0 = (m_se0 >= 2) ? 2 : m_se0 + 1;
        else if (ls == J && m_se0 >= ((m_owe == 1) ? 2 : 1)) begin
          e_end = m_owe; m_owe = 0; m_st = 1; m_idle(); m_se0 = 0;
        end else m_se0 = 0;
      end
    endcase
  endtask

  always @(posedge clk) begin
    e_start = 0; e_end = 0; e_bstb = 0;
    if (!rst_n) begin
      m_st = 0; m_prev = J; m_ones = 0; m_se0 = 0; m_owe = 0; m_bits = 0; m_acc = 0;
      e_byte = 0; e_valid = 0; m_idle();
    end else if (bit_stb) m_step(int'(line_st));
  end

  // per-cycle compare and scenario collection
  int n_start, n_end, end_valid;
  bq_t got;
  bit run = 1'b0;

  always @(negedge clk) if (run) begin
    chk("R2 pkt_start vs model", int'(pkt_start), e_start);
    chk("R4 pkt_end vs model", int'(pkt_end), e_end);
    chk("R3 pkt_valid vs model", int'(pkt_valid), e_valid);
    chk("R8 byte_stb vs model", int'(byte_stb), e_bstb);
    if (e_bstb == 1) chk("R8 byte_data vs model", int'(byte_data), e_byte);
    if (pkt_start) n_start++;
    if (pkt_end) begin n_end++; end_valid = int'(pkt_valid); end
    if (byte_stb) got.push_back(byte_data);
  end

  task automatic send(int ls);
    @(negedge clk); line_st = 2'(ls); bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic send_seq(input int q[$]);
    foreach (q[i]) send(q[i]);
  endtask

  task automatic send_data(input bq_t d);
    int lvl = K, ones = 0;
    foreach (d[i]) for (int k = 0; k < 8; k++) begin
      if (d[i][k]) ones++;
      else begin lvl = (lvl == J) ? K : J; ones = 0; end
      send(lvl);
      if (ones == 6) begin lvl = (lvl == J) ? K : J; send(lvl); ones = 0; end
    end
  endtask

  task automatic send_sync();
    send_seq('{J, K, J, K, J, K, J, K, K});
  endtask

  task automatic send_eop();
    send_seq('{SE0, SE0, J});
  endtask

  task automatic clr();
    n_start = 0; n_end = 0; end_valid = -1; got.delete();
  endtask

  task automatic chk_bytes(string tag, input bq_t ex);
    chk({tag, " byte count"}, got.size(), ex.size());
    foreach (ex[i]) if (i < got.size()) chk({tag, " byte value"}, int'(got[i]), int'(ex[i]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bq_t ex;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pkt_start", int'(pkt_start), 0);
    chk("R1 reset pkt_end", int'(pkt_end), 0);
    chk("R1 reset pkt_valid", int'(pkt_valid), 0);
    chk("R1 reset byte_stb", int'(byte_stb), 0);
    run = 1'b1;

    clr();
    send_seq('{K, J, K, J, K, K});
    chk("R1 no start before first J", n_start, 0);
    send_seq('{SE0, J});

    clr();
    send_sync(); ex = {8'hC3, 8'hA5}; send_data(ex); send_eop();
    chk("R2 start count", n_start, 1);
    chk("R10 end single pulse", n_end, 1);
    chk("R3 valid at end", end_valid, 1);
    chk_bytes("R8 clean packet", ex);

    clr();
    send_sync(); ex = {8'hFF, 8'h3F, 8'h00}; send_data(ex); send_eop();
    chk("R5 stuffed packet valid", end_valid, 1);
    chk_bytes("R5 stuffed bytes", ex);

    clr();
    send_seq('{J, J, K, J, K, J, K, K}); ex = {8'h5A}; send_data(ex); send_eop();
    chk("R3 truncated sync start", n_start, 1);
    chk("R4 end after bad sync", n_end, 1);
    chk("R3 truncated sync invalid", end_valid, 0);
    chk_bytes("R8 bytes of invalid packet", ex);

    clr();
    send_sync(); send_seq('{K, K, K, K, K, K, K});
    send_seq('{K, J, K, J, K, K, J, K, SE0, J, J});
    chk("R6 no restart while deaf", n_start, 1);
    chk("R6 single SE0 not an end", n_end, 0);
    send_seq('{SE0, SE0, J});
    chk("R4 end after stuff violation", n_end, 1);
    chk("R5 violation clears valid", end_valid, 0);
    chk("R6 no bytes after violation", got.size(), 0);

    clr();
    send_seq('{J, K, K});
    send_sync(); ex = {8'h11}; send_data(ex); send_seq('{J, J});
    chk("R7 no start after failed sync", n_start, 0);
    chk("R7 no end after failed sync", n_end, 0);
    send_seq('{SE0, J});
    send_sync(); ex = {8'h7E}; send_data(ex); send_eop();
    chk("R7 recovered start", n_start, 1);
    chk("R7 recovered valid", end_valid, 1);
    chk_bytes("R7 recovered bytes", ex);

    clr();
    send_sync(); ex = {8'h81}; send_data(ex); send_seq('{SE0, J});
    chk("R9 single SE0 gives no end", n_end, 0);
    send_seq('{K, J, K, J, K, K, SE1, K, SE0, SE0, J});
    chk("R9 one start", n_start, 1);
    chk("R9 end after error", n_end, 1);
    chk("R9 error clears valid", end_valid, 0);
    chk_bytes("R9 byte before error", ex);

    clr();
    send_sync(); ex = {8'h00}; send_data(ex); send_seq('{SE0, SE0, K});
    send_seq('{SE0, SE0, J});
    chk("R9 K after EOP SE0 invalid", end_valid, 0);
    chk("R9 one end", n_end, 1);

    clr();
    send_sync(); ex = {8'h96, 8'hE7}; send_data(ex); send_eop();
    chk("R2 final packet start", n_start, 1);
    chk("R3 final packet valid", end_valid, 1);
    chk_bytes("R8 final packet", ex);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule